// File: doc/BRIEF.md
# Alternator Field Regulator Mode Controller

This block picks the operating mode of a vehicle alternator field regulator once per clock. It watches a measured phase frequency, a phase-edge flag, a per-cycle high-phase indicator, a flag that says the battery sits below the voltage setpoint, decoded LIN events, configuration bits and a millisecond tick. From these it steps through a ladder of modes: a quiet sleep mode, a wake mode that fully excites the field to get rotation detected, a pre-excitation mode, regulation with a ramp limit on the field (load-response control, LRC), regulation with the ramp limit lifted, and a forced full-field mode that tries to bring back a missing high phase.

The mode is held in a register and drives an excitation duty-cycle command and an excitation enable. In the regulation modes the duty command follows the battery comparator: maximum (or the externally supplied ramp cap under LRC) when the battery is low, and the programmed minimum otherwise. A shared millisecond window drops the block back to sleep if rotation does not build up in time; a cycle counter ends forced full-field mode after a fixed number of cycles and turns the feature off until the next sleep.

Top module: `altreg_mode_ctrl`

## Requirements
- R1: Mode codes are sleep 0, wake 1, pre-excitation 2, regulation with LRC 3, regulation without LRC 4, forced full field 5. During and after reset the mode is 0, with duty 0 and excitation enable low; mode 0 always drives duty 0 and enable low, and every other mode drives enable high.
- R2: From any mode, the clock after `lin_timeout` is high while `phase_active` is low, or `lin_sleep_cmd` is high while `cfg_lin_sleep_en` is high, the mode is 0; this has priority over every other move. `lin_sleep_cmd` with the enable low, and `lin_timeout` with `phase_active` high, change nothing.
- R3: In mode 0, `phase_edge` moves the block to mode 1 on the next clock; mode 1 drives duty all ones (2^DUTY_W-1). Mode 0 leaves only for mode 1.
- R4: In mode 1, a phase frequency strictly above `thr_start` moves to mode 2 on the next clock and restarts the window; equality does not. Mode 2 drives duty equal to `duty_min`.
- R5: Modes 1 and 2 return to mode 0 on the clock after the TIMEOUT_MS-th `ms_tick` counted since entering the mode, unless an advance happens on that clock.
- R6: In mode 2, a phase frequency strictly above `thr_start` moves to mode 3 on the next clock; equality does not.
- R7: In modes 3, 4 and 5, a phase frequency strictly below `thr_stop` moves to mode 2 on the next clock; equality does not.
- R8: Mode 3 moves to mode 4 only when the frequency is strictly above `thr_lrc` and `batt_low` has been low at least once (the current cycle included) while in mode 3 since the last stay in modes 0 to 2.
- R9: Mode 4 moves to mode 3 when the frequency is strictly below `thr_lrc`; equality keeps mode 4.
- R10: While the forced-field feature is on (loaded from `cfg_phreg_en` in every mode-0 cycle), a `cycle_strobe` with `high_phase` low in mode 3 or 4 moves to mode 5, which drives duty all ones; a `cycle_strobe` with `high_phase` high in mode 5 returns to the mode it came from.
- R11: The FORCE_CYCLES-th `cycle_strobe` with `high_phase` low counted inside mode 5 returns to the mode of origin and turns the feature off, so that later missing-high strobes keep the regulation mode until mode 0 is visited again.
- R12: Mode 3 drives `duty_min` when `batt_low` is low and otherwise the larger of `lrc_cap` and `duty_min`; mode 4 drives `duty_min` when `batt_low` is low and all ones otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| phase_freq | input | FREQ_W | Measured phase frequency |
| phase_edge | input | 1 | Edge seen on the phase input this cycle |
| phase_active | input | 1 | Phase activity present |
| cycle_strobe | input | 1 | Pulse at the end of each phase cycle |
| high_phase | input | 1 | High phase seen in the cycle just ended (valid with strobe) |
| batt_low | input | 1 | Battery voltage below setpoint |
| lin_timeout | input | 1 | Bus inactivity timeout event |
| lin_sleep_cmd | input | 1 | Decoded sleep command |
| cfg_lin_sleep_en | input | 1 | Allows the sleep command to act |
| cfg_phreg_en | input | 1 | Forced-field feature enable |
| thr_stop | input | FREQ_W | Stop threshold |
| thr_start | input | FREQ_W | Start threshold |
| thr_lrc | input | FREQ_W | LRC-disable threshold |
| duty_min | input | DUTY_W | Minimum regulation duty |
| lrc_cap | input | DUTY_W | Ramp-limited duty under LRC |
| mode | output | 3 | Current mode code |
| duty | output | DUTY_W | Excitation duty-cycle command |
| exc_en | output | 1 | Excitation enable |

## Verification
A wrong mode register shows at the `mode` port one clock after the input that should have moved it, and usually also in `duty` and `exc_en` in that same cycle, since both are decoded from the mode. Hidden state is slower to show: a window count off by one only appears as sleep arriving a cycle early or late at the end of a 100 ms wait, a wrong forced-cycle count shows on the strobe that should end mode 5, and a lost setpoint-reached or feature-enable flag only shows at the next LRC-disable crossing or the next missing-high strobe.

// File: rtl/altreg_pkg.sv
package altreg_pkg;

  parameter int ALT_FREQ_W = 12;
  parameter int ALT_DUTY_W = 8;

  typedef logic [ALT_DUTY_W-1:0] duty_t;
  typedef logic [ALT_FREQ_W-1:0] freq_t;

  typedef enum logic [2:0] {
    M_SLEEP    = 3'd0,
    M_WAKE     = 3'd1,
    M_PREX     = 3'd2,
    M_REG_LRC  = 3'd3,
    M_REG_FREE = 3'd4,
    M_FORCE    = 3'd5
  } mode_e;

  localparam duty_t DUTY_FULL = '1;

  // true in any mode that regulates against the setpoint
  function automatic logic in_regulation(input mode_e m);
    return (m == M_REG_LRC) || (m == M_REG_FREE) || (m == M_FORCE);
  endfunction

  // true in the modes guarded by the millisecond window
  function automatic logic in_startup(input mode_e m);
    return (m == M_WAKE) || (m == M_PREX);
  endfunction

  // duty while regulating: floor when the battery is fine,
  // otherwise full field or the ramp cap (never under the floor)
  function automatic duty_t regulate_duty(input logic lrc_on, input logic low,
                                          input duty_t floor_v, input duty_t cap_v);
    if (!low)    return floor_v;
    if (!lrc_on) return DUTY_FULL;
    return (cap_v > floor_v) ? cap_v : floor_v;
  endfunction

endpackage

// File: rtl/altreg_window_timer.sv
module altreg_window_timer #(
  parameter int LIMIT = 100,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  output logic expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  cnt_q <= '0;
    else if (restart)                            cnt_q <= '0;
    else if (tick && (cnt_q != CW'(LIMIT)))      cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == CW'(LIMIT));

endmodule

// File: rtl/altreg_force_guard.sv
module altreg_force_guard #(
  parameter int CYCLES = 8,
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic miss,
  output logic give_up
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!active)  cnt_q <= '0;
    else if (miss)     cnt_q <= cnt_q + 1'b1;
  end

  assign give_up = active && miss && (cnt_q == CW'(CYCLES - 1));

endmodule

// File: rtl/altreg_duty_sel.sv
module altreg_duty_sel
  import altreg_pkg::*;
(
  input  mode_e mode,
  input  logic  batt_low,
  input  duty_t duty_min,
  input  duty_t lrc_cap,
  output duty_t duty,
  output logic  exc_en
);

  always_comb begin
    unique case (mode)
      M_SLEEP:    duty = '0;
      M_WAKE:     duty = DUTY_FULL;
      M_PREX:     duty = duty_min;
      M_REG_LRC:  duty = regulate_duty(1'b1, batt_low, duty_min, lrc_cap);
      M_REG_FREE: duty = regulate_duty(1'b0, batt_low, duty_min, lrc_cap);
      M_FORCE:    duty = DUTY_FULL;
      default:    duty = '0;
    endcase
  end

  assign exc_en = (mode != M_SLEEP);

endmodule

// File: rtl/altreg_mode_ctrl.sv
module altreg_mode_ctrl
  import altreg_pkg::*;
#(
  parameter int TIMEOUT_MS   = 100,
  parameter int FORCE_CYCLES = 8,
  localparam int FREQ_W = ALT_FREQ_W,
  localparam int DUTY_W = ALT_DUTY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic [FREQ_W-1:0] phase_freq,
  input  logic              phase_edge,
  input  logic              phase_active,
  input  logic              cycle_strobe,
  input  logic              high_phase,
  input  logic              batt_low,
  input  logic              lin_timeout,
  input  logic              lin_sleep_cmd,
  input  logic              cfg_lin_sleep_en,
  input  logic              cfg_phreg_en,
  input  logic [FREQ_W-1:0] thr_stop,
  input  logic [FREQ_W-1:0] thr_start,
  input  logic [FREQ_W-1:0] thr_lrc,
  input  logic [DUTY_W-1:0] duty_min,
  input  logic [DUTY_W-1:0] lrc_cap,
  output logic [2:0]        mode,
  output logic [DUTY_W-1:0] duty,
  output logic              exc_en
);

  mode_e state_q, state_d;
  logic  vreg_seen_q;
  logic  ret_free_q;
  logic  phreg_on_q;

  // named events, also watched by the checker
  logic sleep_req, above_start, below_stop, above_lrc, below_lrc;
  logic miss_strobe, hit_strobe, force_entry, lrc_release;
  logic win_restart, win_expired, give_up;

  assign sleep_req   = (lin_timeout && !phase_active) || (lin_sleep_cmd && cfg_lin_sleep_en);
  assign above_start = phase_freq > thr_start;
  assign below_stop  = phase_freq < thr_stop;
  assign above_lrc   = phase_freq > thr_lrc;
  assign below_lrc   = phase_freq < thr_lrc;
  assign miss_strobe = cycle_strobe && !high_phase;
  assign hit_strobe  = cycle_strobe && high_phase;
  assign force_entry = phreg_on_q && miss_strobe;
  assign lrc_release = above_lrc && (vreg_seen_q || !batt_low);

  altreg_window_timer #(.LIMIT(TIMEOUT_MS)) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (win_restart),
    .tick    (ms_tick),
    .expired (win_expired)
  );

  altreg_force_guard #(.CYCLES(FORCE_CYCLES)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (state_q == M_FORCE),
    .miss    (miss_strobe),
    .give_up (give_up)
  );

  mode_e origin;
  assign origin = ret_free_q ? M_REG_FREE : M_REG_LRC;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      M_SLEEP: begin
        if (!sleep_req && phase_edge) state_d = M_WAKE;
      end
      M_WAKE: begin
        if (sleep_req)        state_d = M_SLEEP;
        else if (above_start) state_d = M_PREX;
        else if (win_expired) state_d = M_SLEEP;
      end
      M_PREX: begin
        if (sleep_req)        state_d = M_SLEEP;
        else if (above_start) state_d = M_REG_LRC;
        else if (win_expired) state_d = M_SLEEP;
      end
      M_REG_LRC: begin
        if (sleep_req)        state_d = M_SLEEP;
        else if (below_stop)  state_d = M_PREX;
        else if (force_entry) state_d = M_FORCE;
        else if (lrc_release) state_d = M_REG_FREE;
      end
      M_REG_FREE: begin
        if (sleep_req)        state_d = M_SLEEP;
        else if (below_stop)  state_d = M_PREX;
        else if (force_entry) state_d = M_FORCE;
        else if (below_lrc)   state_d = M_REG_LRC;
      end
      M_FORCE: begin
        if (sleep_req)                state_d = M_SLEEP;
        else if (below_stop)          state_d = M_PREX;
        else if (hit_strobe || give_up) state_d = origin;
      end
      default: state_d = M_SLEEP;
    endcase
  end

  // restart the window on every entry into a start-up mode
  assign win_restart = (state_d != state_q) && in_startup(state_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= M_SLEEP;
      vreg_seen_q <= 1'b0;
      ret_free_q  <= 1'b0;
      phreg_on_q  <= 1'b0;
    end else begin
      state_q <= state_d;

      if (!in_regulation(state_q))                vreg_seen_q <= 1'b0;
      else if (state_q == M_REG_LRC && !batt_low) vreg_seen_q <= 1'b1;

      if (state_d == M_FORCE && state_q != M_FORCE)
        ret_free_q <= (state_q == M_REG_FREE);

      if (state_q == M_SLEEP) phreg_on_q <= cfg_phreg_en;
      else if (give_up)       phreg_on_q <= 1'b0;
    end
  end

  altreg_duty_sel u_duty (
    .mode     (state_q),
    .batt_low (batt_low),
    .duty_min (duty_min),
    .lrc_cap  (lrc_cap),
    .duty     (duty),
    .exc_en   (exc_en)
  );

  assign mode = state_q;

endmodule

// File: rtl/altreg_mode_checks.sv
module altreg_mode_checks #(
  parameter int DUTY_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic [DUTY_W-1:0] duty,
  input logic              exc_en,
  input logic [DUTY_W-1:0] duty_min,
  input logic              sleep_req,
  input logic              above_start,
  input logic              win_expired,
  input logic              give_up
);

  a_r1_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0) |-> (duty == '0 && !exc_en));

  a_r1_awake_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'd0) |-> exc_en);

  a_r2_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> (mode == 3'd0));

  a_r3_sleep_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0) |=> (mode == 3'd0 || mode == 3'd1));

  a_r5_window_end: assert property (@(posedge clk) disable iff (!rst_n)
    (win_expired && (mode == 3'd1 || mode == 3'd2) && !above_start) |=> (mode == 3'd0));

  a_r8_free_source: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'd4) |=> (mode != 3'd4 || $past(mode) == 3'd3 || $past(mode) == 3'd5));

  a_r10_force_full: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5) |-> (duty == '1));

  a_r11_give_up_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    give_up |=> (mode != 3'd5));

  a_r12_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 || mode == 3'd4) |-> (duty >= duty_min));

endmodule

bind altreg_mode_ctrl altreg_mode_checks #(.DUTY_W(altreg_pkg::ALT_DUTY_W)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (mode),
  .duty        (duty),
  .exc_en      (exc_en),
  .duty_min    (duty_min),
  .sleep_req   (sleep_req),
  .above_start (above_start),
  .win_expired (win_expired),
  .give_up     (give_up)
);

// File: tb/tb_altreg_mode_ctrl.sv
`timescale 1ns/1ps
module tb_altreg_mode_ctrl;

  localparam int FW = 12;
  localparam int DW = 8;
  localparam int TMO = 100;
  localparam logic [DW-1:0] FULL = '1;
  localparam logic [DW-1:0] DMIN = 8'd30;
  localparam logic [DW-1:0] CAP  = 8'd120;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic ms_tick = 0, phase_edge = 0, phase_active = 1, cycle_strobe = 0, high_phase = 0;
  logic batt_low = 1, lin_timeout = 0, lin_sleep_cmd = 0, cfg_lin_sleep_en = 0, cfg_phreg_en = 1;
  logic [FW-1:0] phase_freq = '0;
  logic [FW-1:0] thr_stop = 12'd10, thr_start = 12'd20, thr_lrc = 12'd50;
  logic [DW-1:0] duty_min = DMIN, lrc_cap = CAP;
  logic [2:0]    mode;
  logic [DW-1:0] duty;
  logic          exc_en;

  altreg_mode_ctrl #(.TIMEOUT_MS(TMO), .FORCE_CYCLES(8)) dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .phase_freq(phase_freq),
    .phase_edge(phase_edge), .phase_active(phase_active), .cycle_strobe(cycle_strobe),
    .high_phase(high_phase), .batt_low(batt_low), .lin_timeout(lin_timeout),
    .lin_sleep_cmd(lin_sleep_cmd), .cfg_lin_sleep_en(cfg_lin_sleep_en),
    .cfg_phreg_en(cfg_phreg_en), .thr_stop(thr_stop), .thr_start(thr_start),
    .thr_lrc(thr_lrc), .duty_min(duty_min), .lrc_cap(lrc_cap),
    .mode(mode), .duty(duty), .exc_en(exc_en)
  );

  typedef struct {
    logic          chk;
    logic [2:0]    m;
    logic [DW-1:0] d;
    string         tag;
  } exp_t;

  exp_t sb[$];
  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic compare(input logic [2:0] m, input logic [DW-1:0] d, input string tag);
    n_checks++;
    if (mode !== m || duty !== d || exc_en !== (m != 3'd0)) begin
      n_fail++;
      $display("FAIL %s: mode=%0d duty=%0d en=%0b expected mode=%0d duty=%0d en=%0b",
               tag, mode, duty, exc_en, m, d, (m != 3'd0));
    end
  endtask

  // monitor: one popped item per clock, sampled after the edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      if (it.chk) compare(it.m, it.d, it.tag);
    end
  end

  // driver: inputs are already set at a falling edge; push expectation, advance
  task automatic step(input logic [2:0] m, input logic [DW-1:0] d, input string tag);
    exp_t it;
    it.chk = 1; it.m = m; it.d = d; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(3'd0, '0, "R1 in reset");
    rst_n = 1'b1;
    step(3'd0, '0, "R1 after reset");
    step(3'd0, '0, "R3 stays asleep without edge");

    phase_edge = 1; step(3'd1, FULL, "R3 edge wakes");
    phase_edge = 0;
    phase_freq = 12'd20; step(3'd1, FULL, "R4 start equality holds wake");
    phase_freq = 12'd21; step(3'd2, DMIN, "R4 above start to pre-excitation");
    phase_freq = 12'd20; step(3'd2, DMIN, "R6 start equality holds pre");
    phase_freq = 12'd21; step(3'd3, CAP, "R6 above start to LRC regulation");

    phase_freq = 12'd60; batt_low = 1;
    step(3'd3, CAP, "R8 no setpoint yet, stays with LRC");
    step(3'd3, CAP, "R12 capped duty under LRC");
    batt_low = 0; step(3'd4, DMIN, "R8 setpoint reached, LRC lifted");
    batt_low = 1; step(3'd4, FULL, "R12 full duty without LRC");
    lrc_cap = 8'd10; step(3'd4, FULL, "R12 cap ignored without LRC");

    lin_sleep_cmd = 1; step(3'd4, FULL, "R2 sleep command disabled by config");
    lin_sleep_cmd = 0;
    lin_timeout = 1; phase_active = 1; step(3'd4, FULL, "R2 timeout with phase activity");
    lin_timeout = 0;

    phase_freq = 12'd50; step(3'd4, FULL, "R9 LRC threshold equality holds");
    phase_freq = 12'd40; step(3'd3, DMIN, "R9 below LRC threshold, cap under floor");
    lrc_cap = CAP; step(3'd3, CAP, "R12 cap above floor");

    cycle_strobe = 1; high_phase = 0; step(3'd5, FULL, "R10 missing high forces field");
    cycle_strobe = 0; step(3'd5, FULL, "R10 forced holds between strobes");
    cycle_strobe = 1; high_phase = 1; step(3'd3, CAP, "R10 high phase returns to LRC");
    high_phase = 0; step(3'd5, FULL, "R10 forced again");
    for (int i = 1; i <= 7; i++) step(3'd5, FULL, "R11 forced cycle below limit");
    step(3'd3, CAP, "R11 eighth miss returns to origin");
    step(3'd3, CAP, "R11 feature off, miss ignored");
    cycle_strobe = 0;

    phase_freq = 12'd10; step(3'd3, CAP, "R7 stop equality holds regulation");
    phase_freq = 12'd9;  step(3'd2, DMIN, "R7 below stop to pre-excitation");
    ms_tick = 1;
    for (int i = 1; i < TMO; i++) step(3'd2, DMIN, "R5 pre-excitation window running");
    step(3'd2, DMIN, "R5 last tick still pre-excitation");
    step(3'd0, '0, "R5 window expired in pre-excitation");
    ms_tick = 0;

    phase_edge = 1; step(3'd1, FULL, "R3 edge wakes again");
    phase_edge = 0;
    lin_sleep_cmd = 1; cfg_lin_sleep_en = 1; step(3'd0, '0, "R2 enabled sleep command");
    lin_sleep_cmd = 0;
    phase_edge = 1; step(3'd1, FULL, "R3 edge wakes");
    phase_edge = 0;
    lin_timeout = 1; phase_active = 0; step(3'd0, '0, "R2 timeout without phase");
    lin_timeout = 0; phase_active = 1;

    phase_edge = 1; step(3'd1, FULL, "R3 edge before wake window");
    phase_edge = 0; ms_tick = 1;
    for (int i = 1; i < TMO; i++) step(3'd1, FULL, "R5 wake window running");
    step(3'd1, FULL, "R5 last tick still wake");
    step(3'd0, '0, "R5 window expired in wake");
    ms_tick = 0;

    phase_edge = 1; step(3'd1, FULL, "R3 wake for feature reload");
    phase_edge = 0;
    phase_freq = 12'd30; step(3'd2, DMIN, "R4 advance");
    step(3'd3, CAP, "R6 advance");
    cycle_strobe = 1; step(3'd5, FULL, "R10 feature reloaded in sleep");
    cycle_strobe = 0;
    phase_freq = 12'd5; step(3'd2, DMIN, "R7 stop leaves forced mode");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule